// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets an external master borrow the shared external memory bus. The master pulls an active-low hold request; the arbiter synchronises it and waits until the local bus controller has finished the cycle now running. It then blocks new local cycles, acknowledges on an active-low acknowledge pin and floats the bus pins in a fixed order: address first, then the control strobes. While the bus is away, an active-low bus-request output tells the master that the local controller wants the bus back for a cycle of its own.

When the master withdraws its request, the arbiter drives the pins again in the same clock as the acknowledge returns high. It holds the bus controller stalled for one more state, so a local cycle that was waiting starts on the first state after the bus is driven. The whole hold function is gated by an enable control bit. With the bit clear, the hold request pin is ignored, and the other two pins are left to their alternate use as ordinary port pins.

Top module: `bus_hold_arb`

## Requirements
- R1: While rst_n is low and after reset, hold_ack_n=1, bus_req_n=1, addr_oe=1, ctrl_oe=1 and stall=0.
- R2: With hold_en=0, hold_req_n has no effect: hold_ack_n stays 1, stall stays 0, both output enables stay 1 and bus_req_n stays 1, even with local_pend=1.
- R3: hold_req_n passes through SYNC_STAGES (default 2) flops. With the bus idle, a request driven low before clock edge 1 gives hold_ack_n=0 after edge SYNC_STAGES+1 and not earlier.
- R4: A running cycle (cyc_active=1) is never cut short. If it has L clocks left, cyc_done=1 in its last one, hold_ack_n falls after edge max(SYNC_STAGES+1, L).
- R5: stall=1 from the first clock in which the synchronised request is visible (after edge SYNC_STAGES) until one clock after the bus is driven again.
- R6: addr_oe falls one clock after hold_ack_n falls, and ctrl_oe falls one clock after addr_oe. The control pins never float while the address is driven.
- R7: On release, hold_ack_n rises SYNC_STAGES+1 edges after hold_req_n returns high. At that same edge addr_oe=1 and ctrl_oe=1. stall drops one edge later, so a pending local cycle may start in the first state after the bus is driven again.
- R8: bus_req_n=0 one clock after local_pend=1 while the bus is held (hold_ack_n=0). It returns to 1 at the edge where hold_ack_n rises, and it is never 0 while hold_ack_n=1.
- R9: Clearing hold_en while the bus is held releases it at the next edge: hold_ack_n=1 and both output enables 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_en | input | 1 | Enable control bit for the hold function (1 = enabled) |
| hold_req_n | input | 1 | Asynchronous hold request from the external master, active low |
| cyc_active | input | 1 | Bus controller has a cycle in progress |
| cyc_done | input | 1 | Current clock is the last one of that cycle |
| local_pend | input | 1 | Bus controller has an external cycle waiting |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_req_n | output | 1 | Local bus request while held, active low |
| addr_oe | output | 1 | Drive enable for the address pins |
| ctrl_oe | output | 1 | Drive enable for the control strobe pins |
| stall | output | 1 | Tells the bus controller not to start a new cycle |

## Verification
The bench sweeps the number of clocks left in the running cycle from zero to well past the synchroniser depth. It checks the exact edge at which the acknowledge falls, so a design that grants mid-cycle or skips a synchroniser stage shows an early grant. Each run then checks the one-clock float steps and the re-drive edge. A design that floats control before address, or drives pins after the acknowledge rises, fails there. The local-request pin is tested while held and across the release. A design with a disabled enable bit that still reacts to the request, or that keeps holding after the bit is cleared, is caught by dedicated runs.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_ACK   = 3'd2,
        ST_FLTA  = 3'd3,
        ST_HELD  = 3'd4,
        ST_REDRV = 3'd5
    } bha_state_e;

    typedef struct packed {
        bha_state_e state;
        logic       breq;
    } bha_regs_t;

    function automatic logic is_granted(bha_state_e s);
        return (s == ST_ACK) || (s == ST_FLTA) || (s == ST_HELD);
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_n};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic hold_sync_n,
    input  logic cyc_active,
    input  logic cyc_done,
    input  logic local_pend,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic addr_oe,
    output logic ctrl_oe,
    output logic stall
);
    bha_regs_t r_d, r_q;
    logic      hold_seen;
    logic      bus_free;

    assign hold_seen = hold_en && !hold_sync_n;
    assign bus_free  = !cyc_active || cyc_done;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_RUN:   if (hold_seen) r_d.state = bus_free ? ST_ACK : ST_DRAIN;
            ST_DRAIN: begin
                if (!hold_seen)    r_d.state = ST_RUN;
                else if (bus_free) r_d.state = ST_ACK;
            end
            ST_ACK:   r_d.state = ST_FLTA;
            ST_FLTA:  r_d.state = ST_HELD;
            ST_HELD:  if (!hold_seen) r_d.state = ST_REDRV;
            ST_REDRV: r_d.state = ST_RUN;
            default:  r_d.state = ST_RUN;
        endcase
        r_d.breq = local_pend && is_granted(r_d.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_RUN;
            r_q.breq  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_ack_n = !is_granted(r_q.state);
    assign addr_oe    = !((r_q.state == ST_FLTA) || (r_q.state == ST_HELD));
    assign ctrl_oe    = (r_q.state != ST_HELD);
    assign stall      = (r_q.state != ST_RUN) || hold_seen;
    assign bus_req_n  = !r_q.breq;

    // R6: address floats only under an active acknowledge
    a_r6_addr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> !hold_ack_n);
    // R6: control never floats while the address is driven
    a_r6_ctrl_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_oe |-> !addr_oe);
    // R6: one-clock step from acknowledge to address float
    a_r6_float_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |=> (!addr_oe && ctrl_oe));
    // R7: pins driven no later than the acknowledge rising, stall still on
    a_r7_redrive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> (addr_oe && ctrl_oe && stall));
    // R4: an unfinished cycle blocks the grant
    a_r4_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack_n && cyc_active && !cyc_done) |=> hold_ack_n);
    // R8: local request only while the bus is away
    a_r8_breq_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> !hold_ack_n);
    // R2: disabled function never grants
    a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_en && hold_ack_n) |=> hold_ack_n);

endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic hold_req_n,
    input  logic cyc_active,
    input  logic cyc_done,
    input  logic local_pend,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic addr_oe,
    output logic ctrl_oe,
    output logic stall
);
    logic hold_sync_n;

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (hold_req_n),
        .sync_n  (hold_sync_n)
    );

    bha_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_en     (hold_en),
        .hold_sync_n (hold_sync_n),
        .cyc_active  (cyc_active),
        .cyc_done    (cyc_done),
        .local_pend  (local_pend),
        .hold_ack_n  (hold_ack_n),
        .bus_req_n   (bus_req_n),
        .addr_oe     (addr_oe),
        .ctrl_oe     (ctrl_oe),
        .stall       (stall)
    );

endmodule

// File: tb/tb_bus_hold_arb.sv
module tb_bus_hold_arb;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n, hold_en, hold_req_n, cyc_active, cyc_done, local_pend;
    logic hold_ack_n, bus_req_n, addr_oe, ctrl_oe, stall;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    bus_hold_arb #(.SYNC_STAGES(S)) dut (
        .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .hold_req_n(hold_req_n),
        .cyc_active(cyc_active), .cyc_done(cyc_done), .local_pend(local_pend),
        .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .addr_oe(addr_oe),
        .ctrl_oe(ctrl_oe), .stall(stall)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic grant_run(input int len);
        int exp_e;
        exp_e = (len > S + 1) ? len : S + 1;
        cyc_active = (len > 0);
        cyc_done   = (len == 1);
        hold_req_n = 1'b0;
        for (int e = 1; e <= exp_e + 3; e++) begin
            step();
            cyc_active = (e < len);
            cyc_done   = (e == len - 1);
            check(len <= S + 1 ? "R3 grant edge" : "R4 grant edge", hold_ack_n, !(e >= exp_e));
            check("R6 address float", addr_oe, !(e >= exp_e + 1));
            check("R6 control float", ctrl_oe, !(e >= exp_e + 2));
            check("R5 stall", stall, e >= S);
        end
        local_pend = 1'b1;
        step();
        check("R8 breq while held", bus_req_n, 1'b0);
        hold_req_n = 1'b1;
        for (int e = 1; e <= S + 3; e++) begin
            step();
            check("R7 release ack", hold_ack_n, e >= S + 1);
            check("R7 address redrive", addr_oe, e >= S + 1);
            check("R7 control redrive", ctrl_oe, e >= S + 1);
            check("R7 stall release", stall, !(e >= S + 2));
            check("R8 breq release", bus_req_n, e >= S + 1);
        end
        local_pend = 1'b0;
        step();
        step();
    endtask

    initial begin
        rst_n = 1'b0; hold_en = 1'b1; hold_req_n = 1'b1;
        cyc_active = 1'b0; cyc_done = 1'b0; local_pend = 1'b0;
        repeat (3) step();
        check("R1 reset ack", hold_ack_n, 1'b1);
        check("R1 reset breq", bus_req_n, 1'b1);
        check("R1 reset addr_oe", addr_oe, 1'b1);
        check("R1 reset ctrl_oe", ctrl_oe, 1'b1);
        check("R1 reset stall", stall, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", hold_ack_n, 1'b1);

        for (int len = 0; len <= 8; len++) grant_run(len);

        // R2: disabled function
        hold_en = 1'b0; hold_req_n = 1'b0; local_pend = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step();
            check("R2 disabled ack", hold_ack_n, 1'b1);
            check("R2 disabled stall", stall, 1'b0);
            check("R2 disabled breq", bus_req_n, 1'b1);
            check("R2 disabled addr_oe", addr_oe, 1'b1);
            check("R2 disabled ctrl_oe", ctrl_oe, 1'b1);
        end
        hold_req_n = 1'b1; local_pend = 1'b0; hold_en = 1'b1;
        repeat (4) step();

        // R9: clearing the enable while held
        hold_req_n = 1'b0;
        repeat (S + 3) step();
        check("R9 held before clear", ctrl_oe, 1'b0);
        hold_en = 1'b0;
        step();
        check("R9 ack released", hold_ack_n, 1'b1);
        check("R9 address driven", addr_oe, 1'b1);
        check("R9 control driven", ctrl_oe, 1'b1);
        step();
        check("R9 stall cleared", stall, 1'b0);
        hold_req_n = 1'b1; hold_en = 1'b1;
        repeat (4) step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule